// File: doc/BRIEF.md
# DMA Channel Request Combiner with Fixed-Priority Arbiter

This block sits in front of a seven-channel DMA engine. Many peripherals raise DMA request lines; a parameter table assigns each line to one channel. A line counts only while its own DMA enable bit is set. The block registers the incoming lines once and holds each qualified request as pending. It then merges the pending lines of each channel with a plain OR.

A channel asks for service when its channel enable bit is set and it has a pending peripheral request. A channel whose software memory-to-memory trigger bit is set also asks for service, with no peripheral request needed. A fixed arbiter grants the lowest-numbered requesting channel. The grant is held until the engine reports transfer complete. After that the grant is released for one cycle and arbitration starts again. The served channel's pending sources are cleared on completion, so a short pulse is neither lost nor served twice.

The outputs are a one-hot grant vector and an encoded channel number. Only one source per channel should be enabled at a time, because the OR cannot tell sources apart.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant_oh` is all zeros and `grant_idx` is 0.
- R2: A request line whose `src_dma_en` bit is 0 is never captured and never causes a grant. Once its enable bit is set, the same held line leads to a grant of its channel.
- R3: Every source listed for a channel in `CH_MAP` can raise that channel's request on its own. With the default map, channel k (1..7) is served by sources 2k-2 and 2k-1.
- R4: A channel whose `ch_en` bit is 0 is never granted, whether it has peripheral requests or its memory-to-memory bit set.
- R5: An enabled channel with its `ch_m2m` bit set is granted with no peripheral request. If the arbiter is idle, the grant appears on the first rising edge after the bit is set.
- R6: When several channels request while the arbiter is idle, the lowest-numbered one is granted.
- R7: At most one bit of `grant_oh` is set. `grant_idx` is the channel number 1..7, which is the set bit position plus one, or 0 when no bit is set.
- R8: A grant holds unchanged until `xfer_done` is seen high at a rising edge, even if a higher-priority request arrives in the meantime.
- R9: When `xfer_done` is high at a rising edge while a grant is held, the grant is zero after that edge. Arbitration then takes place on the following edge.
- R10: A request pulse that lasts one cycle stays pending until its channel's transfer completes, and then it is cleared. A request line held high reaches a grant after the third rising edge from when it is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Peripheral DMA request lines |
| src_dma_en | input | N_SRC | Per-peripheral DMA enable bits |
| ch_en | input | N_CH | Per-channel enable bits |
| ch_m2m | input | N_CH | Per-channel memory-to-memory software trigger bits |
| xfer_done | input | 1 | Transfer complete for the currently granted channel |
| grant_oh | output | N_CH | One-hot grant, bit 0 is channel 1 |
| grant_idx | output | IDX_W | Granted channel number 1..7, 0 for none |

## Verification
Two events can land in the same cycle. One is the completion of a held grant. The other is a new request from a higher-priority channel, or a pending pulse that arrived during the held transfer. The bench raises a peripheral pulse or a memory-to-memory trigger while a lower-priority channel holds the grant, and checks over several cycles that the grant does not move. It then pulses `xfer_done` and checks two things: that the grant is zero for exactly one cycle, and that on the next edge it goes to the higher-priority channel. A later completion of that channel must leave nothing pending behind.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;

  localparam int DEF_CH  = 7;
  localparam int DEF_SRC = 14;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  // Default routing: channel c (0-based) takes sources 2c and 2c+1.
  function automatic logic [DEF_CH-1:0][DEF_SRC-1:0] default_map();
    logic [DEF_CH-1:0][DEF_SRC-1:0] m;
    for (int c = 0; c < DEF_CH; c++) begin
      m[c]          = '0;
      m[c][2*c]     = 1'b1;
      m[c][2*c + 1] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dma_req_capture.sv
`timescale 1ns/1ps
// Registers raw request lines once, then keeps qualified requests pending
// until the channel that owns them completes a transfer.
module dma_req_capture #(
  parameter int N_SRC = 14,
  parameter int N_CH  = 7,
  parameter logic [N_CH-1:0][N_SRC-1:0] CH_MAP = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_dma_en,
  input  logic             done_valid,
  input  logic [N_CH-1:0]  grant_oh,
  output logic [N_SRC-1:0] pend
);

  logic [N_SRC-1:0] req_s;
  logic [N_SRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (done_valid && grant_oh[c]) clr_mask = clr_mask | CH_MAP[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_s <= '0;
      pend  <= '0;
    end else begin
      req_s <= src_req;
      // a fresh capture wins over a clear in the same cycle
      pend  <= (pend & ~clr_mask) | (req_s & src_dma_en);
    end
  end

endmodule

// File: rtl/dma_ch_combine.sv
`timescale 1ns/1ps
// Per-channel OR of gated pending sources, plus the software trigger,
// qualified by the channel enable.
module dma_ch_combine #(
  parameter int N_SRC = 14,
  parameter int N_CH  = 7,
  parameter logic [N_CH-1:0][N_SRC-1:0] CH_MAP = '0
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] src_dma_en,
  input  logic [N_CH-1:0]  ch_en,
  input  logic [N_CH-1:0]  ch_m2m,
  output logic [N_CH-1:0]  ch_req
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic periph_any;
    assign periph_any = |(pend & src_dma_en & CH_MAP[c]);
    assign ch_req[c]  = ch_en[c] & (periph_any | ch_m2m[c]);
  end

endmodule

// File: rtl/dma_fixed_prio.sv
`timescale 1ns/1ps
// Fixed-priority arbiter, bit 0 highest; grant held until transfer complete.
module dma_fixed_prio
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 7,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  ch_req,
  input  logic             xfer_done,
  output logic [N_CH-1:0]  grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output logic             busy
);

  arb_state_e       state;
  logic [N_CH-1:0]  pick_oh;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (ch_req[c]) begin
        pick_oh    = '0;
        pick_oh[c] = 1'b1;
        pick_idx   = IDX_W'(c + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ARB_IDLE;
      grant_oh  <= '0;
      grant_idx <= '0;
    end else begin
      case (state)
        ARB_IDLE: begin
          if (|ch_req) begin
            state     <= ARB_BUSY;
            grant_oh  <= pick_oh;
            grant_idx <= pick_idx;
          end
        end
        default: begin
          if (xfer_done) begin
            state     <= ARB_IDLE;
            grant_oh  <= '0;
            grant_idx <= '0;
          end
        end
      endcase
    end
  end

  assign busy = (state == ARB_BUSY);

endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = DEF_CH,
  parameter int N_SRC = DEF_SRC,
  parameter logic [N_CH-1:0][N_SRC-1:0] CH_MAP = default_map(),
  localparam int IDX_W = $clog2(N_CH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_dma_en,
  input  logic [N_CH-1:0]  ch_en,
  input  logic [N_CH-1:0]  ch_m2m,
  input  logic             xfer_done,
  output logic [N_CH-1:0]  grant_oh,
  output logic [IDX_W-1:0] grant_idx
);

  logic [N_SRC-1:0] pend;
  logic [N_CH-1:0]  ch_req;
  logic             busy;

  dma_req_capture #(.N_SRC(N_SRC), .N_CH(N_CH), .CH_MAP(CH_MAP)) cap_i (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .src_dma_en (src_dma_en),
    .done_valid (xfer_done & busy),
    .grant_oh   (grant_oh),
    .pend       (pend)
  );

  dma_ch_combine #(.N_SRC(N_SRC), .N_CH(N_CH), .CH_MAP(CH_MAP)) comb_i (
    .pend       (pend),
    .src_dma_en (src_dma_en),
    .ch_en      (ch_en),
    .ch_m2m     (ch_m2m),
    .ch_req     (ch_req)
  );

  dma_fixed_prio #(.N_CH(N_CH), .IDX_W(IDX_W)) arb_i (
    .clk       (clk),
    .rst       (rst),
    .ch_req    (ch_req),
    .xfer_done (xfer_done),
    .grant_oh  (grant_oh),
    .grant_idx (grant_idx),
    .busy      (busy)
  );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
`timescale 1ns/1ps
module dma_req_arbiter_chk #(
  parameter int N_CH  = 7,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CH-1:0]  ch_en,
  input logic             xfer_done,
  input logic [N_CH-1:0]  grant_oh,
  input logic [IDX_W-1:0] grant_idx
);

  logic [N_CH-1:0] idx_dec;
  always_comb begin
    idx_dec = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (int'(grant_idx) == c + 1) idx_dec[c] = 1'b1;
    end
  end

  // R7
  p_onehot_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh));

  // R7
  p_idx_matches_r7: assert property (@(posedge clk) disable iff (rst)
    grant_oh == idx_dec);

  // R8
  p_grant_held_r8: assert property (@(posedge clk) disable iff (rst)
    (grant_oh != '0 && !xfer_done) |=> $stable(grant_oh));

  // R9
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (grant_oh != '0 && xfer_done) |=> grant_oh == '0);

  // R4
  p_enabled_only_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_oh == '0) |=> (grant_oh == '0 || (grant_oh & $past(ch_en)) != '0));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.N_CH(N_CH), .IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ch_en     (ch_en),
  .xfer_done (xfer_done),
  .grant_oh  (grant_oh),
  .grant_idx (grant_idx)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

  localparam int N_CH  = 7;
  localparam int N_SRC = 14;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic [N_SRC-1:0] src_req;
  logic [N_SRC-1:0] src_dma_en;
  logic [N_CH-1:0]  ch_en;
  logic [N_CH-1:0]  ch_m2m;
  logic             xfer_done;
  logic [N_CH-1:0]  grant_oh;
  logic [IDX_W-1:0] grant_idx;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_req_arbiter dut_i (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .src_dma_en (src_dma_en),
    .ch_en      (ch_en),
    .ch_m2m     (ch_m2m),
    .xfer_done  (xfer_done),
    .grant_oh   (grant_oh),
    .grant_idx  (grant_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expect grant on channel k (0 = none): checks both outputs
  task automatic chk_grant(input string req, input int k);
    chk(req, int'(grant_idx), k);
    chk(req, int'(grant_oh), (k == 0) ? 0 : (1 << (k - 1)));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1;
    cyc(1);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; src_req = '0; src_dma_en = '1; ch_en = '1; ch_m2m = '0;
    xfer_done = 1'b0;
    ch_m2m[0] = 1'b1;          // a request is present during reset
    cyc(3);
    chk_grant("R1 in reset", 0);
    ch_m2m = '0;
    rst = 1'b0;
    cyc(1);
    chk_grant("R1 after reset", 0);
    cyc(2);
  endtask

  task automatic t_pulse_single();
    src_req[4] = 1'b1;         // channel 3
    cyc(1);
    src_req[4] = 1'b0;
    cyc(1);
    chk_grant("R10 two edges, not yet", 0);
    cyc(1);
    chk_grant("R10 pulse granted ch3", 3);
    finish_xfer();
    chk_grant("R9 released", 0);
    cyc(3);
    chk_grant("R10 pending cleared", 0);
  endtask

  task automatic t_or_second_src();
    src_req[5] = 1'b1;         // second source of channel 3
    cyc(3);
    chk_grant("R3 second source ch3", 3);
    src_req[5] = 1'b0;
    cyc(2);
    finish_xfer();
    cyc(3);
    chk_grant("R3 idle after", 0);
  endtask

  task automatic t_src_gate();
    src_dma_en[0] = 1'b0;
    src_req[0] = 1'b1;
    cyc(5);
    chk_grant("R2 disabled source", 0);
    src_dma_en[0] = 1'b1;
    cyc(2);
    chk_grant("R2 enabled source ch1", 1);
    src_req[0] = 1'b0;
    cyc(2);
    finish_xfer();
    cyc(3);
    chk_grant("R2 idle after", 0);
  endtask

  task automatic t_ch_disable();
    ch_en[1] = 1'b0;
    ch_m2m[1] = 1'b1;
    src_req[3] = 1'b1;
    cyc(5);
    chk_grant("R4 disabled channel", 0);
    ch_m2m[1] = 1'b0;
    src_req[3] = 1'b0;
    cyc(2);
    ch_en[1] = 1'b1;           // pend of source 3 may remain; clear it
    cyc(1);
    if (grant_idx != 0) begin
      cyc(1);
      finish_xfer();
    end
    cyc(3);
  endtask

  task automatic t_m2m();
    ch_m2m[5] = 1'b1;
    cyc(1);
    chk_grant("R5 m2m ch6 one edge", 6);
    ch_m2m[5] = 1'b0;
    finish_xfer();
    cyc(2);
    chk_grant("R5 idle after", 0);
  endtask

  task automatic t_prio_hold();
    ch_m2m = 7'b1001010;       // channels 7, 4, 2
    cyc(1);
    chk_grant("R6 lowest wins ch2", 2);
    ch_m2m[0] = 1'b1;          // higher priority arrives
    cyc(4);
    chk_grant("R8 held ch2", 2);
    ch_m2m[1] = 1'b0;
    finish_xfer();
    chk_grant("R9 gap after done", 0);
    cyc(1);
    chk_grant("R6 ch1 after release", 1);
    ch_m2m[0] = 1'b0;
    finish_xfer();
    cyc(1);
    chk_grant("R6 ch4 next", 4);
    ch_m2m[3] = 1'b0;
    finish_xfer();
    cyc(1);
    chk_grant("R6 ch7 last", 7);
    ch_m2m[6] = 1'b0;
    finish_xfer();
    cyc(2);
    chk_grant("R7 none", 0);
  endtask

  task automatic t_pend_during_grant();
    ch_m2m[6] = 1'b1;
    cyc(1);
    chk_grant("R5 ch7", 7);
    src_req[0] = 1'b1;
    cyc(1);
    src_req[0] = 1'b0;
    cyc(4);
    chk_grant("R8 held ch7 over pulse", 7);
    ch_m2m[6] = 1'b0;
    finish_xfer();
    chk_grant("R9 released", 0);
    cyc(1);
    chk_grant("R10 pulse remembered ch1", 1);
    finish_xfer();
    cyc(3);
    chk_grant("R10 cleared after serve", 0);
  endtask

  initial begin
    t_reset();
    t_pulse_single();
    t_or_second_src();
    t_src_gate();
    t_ch_disable();
    t_m2m();
    t_prio_hold();
    t_pend_during_grant();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule